// File: doc/BRIEF.md
# Programmable-Priority Multimaster Bus Arbiter

This block decides which of several masters owns a shared, synchronous system bus. Every master presents a request, a 2-bit priority that may change from one request to the next, a lock flag, a burst flag and a beat count. The block answers with a one-hot grant, the index of the owner, a transfer-valid flag and a flag marking the final acknowledged beat. A transfer advances only on slave acknowledges.

The next owner is chosen during the final acknowledged beat of the current transfer. A new owner can therefore start on the very next cycle, with no idle cycle between owners. The grant stays put for the whole of a burst. A fixed burst stops after a programmed number of beats. A variable burst stops on the first acknowledged beat that arrives while the owner holds its burst flag low.

An owner that keeps its lock flag high at the moment of arbitration keeps the bus, and every other master waits. When nobody requests, the grant stays parked on the last owner and no transfer is signalled. Address decoding and the read and write data paths sit outside this block.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset the grant is parked on master 0 (`gnt` = 0001), `owner_id` is 0, and both `xfer_valid` and `last_beat` are low.
- R2: `gnt` is one-hot in every cycle, and `owner_id` is the index of its set bit.
- R3: At an arbitration point, the eligible requester with the numerically largest 2-bit priority wins. The priority of master i is `mst_prio[2i+1:2i]`, and 3 is the highest value.
- R4: When several eligible requesters share the highest priority, the winner is the first one found in the order owner+1, owner+2, …, wrapping round, with the current owner checked last.
- R5: A transfer begun with `mst_burst` low lasts `mst_blen`+1 acknowledged beats. The beat count of master i is `mst_blen[4i+3:4i]`, sampled in the arbitration cycle. `last_beat` is high exactly in the cycle of the final acknowledge.
- R6: A transfer begun with `mst_burst` high ignores the beat count. It ends on the first acknowledged beat that arrives while the owner's `mst_burst` is low.
- R7: When `last_beat` is high and an eligible request is present, the next cycle shows the winner granted with `xfer_valid` still high, so there is no idle cycle between owners.
- R8: With no eligible request, `xfer_valid` falls after the final beat and stays low, and `gnt` keeps the last owner.
- R9: An arbitration point is the final beat of a transfer or any cycle with no transfer. If the owner's `mst_lock` bit is high at that point, only the owner is eligible, whatever priority the other masters hold. The lock is released once the owner lowers `mst_lock` before an arbitration point.
- R10: While `xfer_valid` is high and `last_beat` is low, `gnt` does not change, even if a master with a higher priority requests.
- R11: `slv_ack` has no effect while `xfer_valid` is low: `gnt` and `xfer_valid` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req | input | N | Per-master bus request |
| mst_prio | input | N*2 | Per-master priority, 2 bits each; the larger value wins |
| mst_lock | input | N | Per-master lock flag |
| mst_burst | input | N | Per-master burst flag: selects variable mode at start and continues the burst while high |
| mst_blen | input | N*4 | Per-master fixed-burst beat count minus one |
| slv_ack | input | 1 | Slave acknowledge of one beat |
| gnt | output | N | One-hot grant |
| owner_id | output | log2(N) | Index of the granted master |
| xfer_valid | output | 1 | A transfer is in progress |
| last_beat | output | 1 | The current acknowledge ends the transfer; the next owner is chosen in this cycle |

## Verification
The hardest situation to reach from the ports is the overlapped hand-over. It needs a waiting higher-priority request to be ignored for a whole burst with gaps between beats, and then honoured on exactly the cycle after the final acknowledge. The stimulus gets there by raising that request during a four-beat fixed burst and arming it for a variable burst. The bench then checks that the new owner holds `xfer_valid` with no gap. Lock is exercised both while the locked owner keeps requesting and while it sits idle with lock high, so that others must wait across empty cycles. A table of arbitration cases walks the round-robin pointer through ties, wrap-round and self-regrant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {BM_FIXED = 1'b0, BM_VAR = 1'b1} bmode_e;

  // position reached by stepping `off` places after `base` on a ring of n
  function automatic int ring_idx(int base, int off, int n);
    return (base + off) % n;
  endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N  = 4,
  parameter int PW = 2,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  input  logic [IW-1:0]   last_idx,
  output logic [IW-1:0]   win_idx,
  output logic            any_win
);
  logic [PW-1:0] best;

  always_comb begin
    win_idx = last_idx;
    best    = '0;
    any_win = 1'b0;
    // scan starting after the last owner; strict compare keeps the earliest tie
    for (int off = 1; off <= N; off++) begin
      if (cand[arb_pkg::ring_idx(int'(last_idx), off, N)] &&
          (!any_win || prio[arb_pkg::ring_idx(int'(last_idx), off, N)*PW +: PW] > best)) begin
        any_win = 1'b1;
        best    = prio[arb_pkg::ring_idx(int'(last_idx), off, N)*PW +: PW];
        win_idx = IW'(arb_pkg::ring_idx(int'(last_idx), off, N));
      end
    end
  end
endmodule

// File: rtl/arb_beat_track.sv
module arb_beat_track #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] start_len,
  input  logic          start_var,
  input  logic          beat,
  input  logic          hold,
  output logic          fin
);
  import arb_pkg::*;

  logic [BW-1:0] left_q;
  bmode_e        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      mode_q <= BM_FIXED;
    end else if (start) begin
      left_q <= start_len;
      mode_q <= start_var ? BM_VAR : BM_FIXED;
    end else if (beat && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  // R5 / R6: end condition of the current beat
  assign fin = (mode_q == BM_VAR) ? !hold : (left_q == '0);
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int N  = 4,
  parameter int PW = 2,
  parameter int BW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    mst_req,
  input  logic [N*PW-1:0] mst_prio,
  input  logic [N-1:0]    mst_lock,
  input  logic [N-1:0]    mst_burst,
  input  logic [N*BW-1:0] mst_blen,
  input  logic            slv_ack,
  output logic [N-1:0]    gnt,
  output logic [IW-1:0]   owner_id,
  output logic            xfer_valid,
  output logic            last_beat
);
  logic [IW-1:0] owner_q;
  logic          busy_q;

  // named internal events
  logic          owner_locked;
  logic [N-1:0]  owner_mask;
  logic [N-1:0]  eligible;
  logic [IW-1:0] win_idx;
  logic          any_win;
  logic          beat_ok;
  logic          end_ok;
  logic          xfer_done;
  logic          arb_point;
  logic          start_xfer;

  assign owner_mask   = N'(1) << owner_q;
  assign owner_locked = mst_lock[owner_q];
  assign eligible     = owner_locked ? (mst_req & owner_mask) : mst_req;

  arb_pick #(.N(N), .PW(PW)) u_pick (
    .cand     (eligible),
    .prio     (mst_prio),
    .last_idx (owner_q),
    .win_idx  (win_idx),
    .any_win  (any_win)
  );

  assign beat_ok = busy_q && slv_ack;

  arb_beat_track #(.BW(BW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_xfer),
    .start_len (mst_blen[win_idx*BW +: BW]),
    .start_var (mst_burst[win_idx]),
    .beat      (beat_ok),
    .hold      (mst_burst[owner_q]),
    .fin       (end_ok)
  );

  assign xfer_done  = beat_ok && end_ok;
  assign arb_point  = !busy_q || xfer_done;
  assign start_xfer = arb_point && any_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      busy_q  <= 1'b0;
    end else if (start_xfer) begin
      owner_q <= win_idx;
      busy_q  <= 1'b1;
    end else if (xfer_done) begin
      busy_q  <= 1'b0;
    end
  end

  assign gnt        = owner_mask;
  assign owner_id   = owner_q;
  assign xfer_valid = busy_q;
  assign last_beat  = xfer_done;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  mst_req,
  input logic [N-1:0]  mst_lock,
  input logic [N-1:0]  gnt,
  input logic [IW-1:0] owner_id,
  input logic          xfer_valid,
  input logic          last_beat
);
  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(gnt) && gnt[owner_id]);

  assert_gnt_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !last_beat) |=> $stable(gnt));

  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && (mst_lock[owner_id] ? mst_req[owner_id] : (|mst_req))) |=> xfer_valid);

  assert_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_valid && mst_req == '0) |=> ($stable(gnt) && !xfer_valid));

  assert_idle_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |-> !last_beat);

  assert_lock_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && mst_lock[owner_id]) |=> $stable(gnt));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mst_req    (mst_req),
  .mst_lock   (mst_lock),
  .gnt        (gnt),
  .owner_id   (owner_id),
  .xfer_valid (xfer_valid),
  .last_beat  (last_beat)
);

// File: tb/prio_bus_arbiter_bench.sv
module prio_bus_arbiter_bench;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*PW-1:0] prio = '0;
  logic [N-1:0]  lock = '0;
  logic [N-1:0]  burst = '0;
  logic [N*BW-1:0] blen = '0;
  logic          ack = 1'b0;
  logic [N-1:0]  gnt;
  logic [1:0]    owner_id;
  logic          xfer_valid;
  logic          last_beat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_bus_arbiter #(.N(N), .PW(PW), .BW(BW)) u_prio_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .mst_req(req), .mst_prio(prio), .mst_lock(lock),
    .mst_burst(burst), .mst_blen(blen), .slv_ack(ack), .gnt(gnt),
    .owner_id(owner_id), .xfer_valid(xfer_valid), .last_beat(last_beat)
  );

  // {req[15:12], prio[11:4], expected gnt[3:0]}; owner before row 0 is master 0
  localparam logic [15:0] VEC [0:8] = '{
    16'hF002,  // all tie -> after 0
    16'hF004,  // all tie -> after 1
    16'h5001,  // 0,2 tie, after 2 -> wrap to 0
    16'hAC48,  // m3 prio 3 beats m1 prio 1
    16'hF9A1,  // 0,1,3 at prio 2, after 3 -> 0
    16'hF9A2,  // same, after 0 -> 1
    16'h8008,  // lone m3
    16'h9001,  // 0,3 tie after 3 -> 0
    16'h1001   // self re-grant
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 gnt", 32'(gnt), 32'h1);
    chk("R1 owner", 32'(owner_id), 32'h0);
    chk("R1 valid", 32'(xfer_valid), 32'h0);
    chk("R1 last", 32'(last_beat), 32'h0);

    // R11 acknowledge while idle has no effect
    ack = 1'b1;
    #1 chk("R11 last", 32'(last_beat), 32'h0);
    step();
    chk("R11 gnt", 32'(gnt), 32'h1);
    chk("R11 valid", 32'(xfer_valid), 32'h0);
    ack = 1'b0;

    // arbitration table: R3 priority, R4 round robin, R8 parking
    for (int i = 0; i < 9; i++) begin
      req  = VEC[i][15:12];
      prio = VEC[i][11:4];
      step();
      chk("R3/R4 gnt", 32'(gnt), 32'(VEC[i][3:0]));
      chk("R2 valid", 32'(xfer_valid), 32'h1);
      req = '0;
      ack = 1'b1;
      #1 chk("R5 single last", 32'(last_beat), 32'h1);
      step();
      ack = 1'b0;
      chk("R8 park valid", 32'(xfer_valid), 32'h0);
      chk("R8 park gnt", 32'(gnt), 32'(VEC[i][3:0]));
    end

    // R5 fixed burst of 4 beats on master 2, R10 higher-priority request waits
    prio = 8'h0C;          // m1 prio 3, m2 prio 0
    blen = 16'h0300;       // m2 beat count 3 -> 4 beats
    burst = '0;
    req = 4'b0100;
    step();
    chk("R5 gnt m2", 32'(gnt), 32'h4);
    req = 4'b0010;         // m1 waiting with higher priority
    ack = 1'b1;
    #1 chk("R5 beat1 last", 32'(last_beat), 32'h0);
    step();
    ack = 1'b0;
    step();
    chk("R10 gnt held", 32'(gnt), 32'h4);
    ack = 1'b1;
    #1 chk("R5 beat2 last", 32'(last_beat), 32'h0);
    step();
    #1 chk("R5 beat3 last", 32'(last_beat), 32'h0);
    chk("R10 gnt held2", 32'(gnt), 32'h4);
    step();
    burst = 4'b0010;       // m1 will run a variable burst
    #1 chk("R5 beat4 last", 32'(last_beat), 32'h1);
    step();
    // R7 no idle between owners
    chk("R7 gnt m1", 32'(gnt), 32'h2);
    chk("R7 valid", 32'(xfer_valid), 32'h1);
    req = '0;
    // R6 variable burst continues while burst flag high
    #1 chk("R6 cont1", 32'(last_beat), 32'h0);
    step();
    step();
    burst = '0;
    #1 chk("R6 end", 32'(last_beat), 32'h1);
    step();
    ack = 1'b0;
    chk("R6 idle after", 32'(xfer_valid), 32'h0);
    chk("R8 parked m1", 32'(gnt), 32'h2);

    // R9 lock keeps the grant with master 3
    blen = '0;
    prio = 8'h03;          // m0 prio 3, m3 prio 0
    req = 4'b1000;
    lock = 4'b1000;
    step();
    chk("R9 gnt m3", 32'(gnt), 32'h8);
    req = 4'b1001;
    ack = 1'b1;
    step();
    chk("R9 locked regrant", 32'(gnt), 32'h8);
    chk("R9 locked valid", 32'(xfer_valid), 32'h1);
    lock = '0;             // released before the next arbitration point
    req = 4'b0001;
    #1 chk("R9 last", 32'(last_beat), 32'h1);
    step();
    chk("R9 released", 32'(gnt), 32'h1);
    // idle lock: owner m0 locks with no request, m2 must wait
    lock = 4'b0001;
    req = 4'b0100;
    step();
    ack = 1'b0;
    chk("R9 idle valid", 32'(xfer_valid), 32'h0);
    step();
    chk("R9 idle wait", 32'(gnt), 32'h1);
    lock = '0;
    step();
    chk("R9 idle release", 32'(gnt), 32'h4);
    chk("R9 idle rel valid", 32'(xfer_valid), 32'h1);
    req = '0;
    ack = 1'b1;
    step();
    ack = 1'b0;
    step();
    chk("R8 final park", 32'(gnt), 32'h4);
    chk("R8 final valid", 32'(xfer_valid), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule